// File: doc/BRIEF.md
# Serial Frame Transmitter

This block turns one byte into an asynchronous serial frame on a single line, `tx`. A frame has ten bit slots. Slot 0 is the start bit (0). Slots 1 to 8 carry the byte with the least-significant bit first. Slot 9 is the stop bit (1). Each slot lasts `CLKS_PER_BIT` clock cycles. The line rests high between frames.

A client raises `start` with a byte on `data_in`. The block takes the request at the next clock edge when it is idle and copies the byte into an internal register, so the client may change `data_in` right away. `busy` is high for the whole frame, and requests made while it is high are dropped.

The controller has two states:
- `ST_IDLE`: the line rests high and the block waits for a request.
- `ST_SEND`: a frame is on the line.

It has two transitions:
- `accept` goes from `ST_IDLE` to `ST_SEND` when `start` is high.
- `finish` goes from `ST_SEND` back to `ST_IDLE` after the last cycle of slot 9.

In `ST_SEND`, a 4-bit slot index picks the level on `tx`, and an inner cycle counter times each slot.

Top module: `serial_frame_tx`

## Requirements
- R1: While sending, the line carries the slots in this order. Slot 0 is 0. Slots 1 to 8 are `data_in` bits 0 to 7 as captured at acceptance. Slot 9 is 1.
- R2: Each slot holds its level on `tx` for exactly `CLKS_PER_BIT` consecutive clock cycles. The first slot begins in the cycle right after the accepting edge.
- R3: While the block is idle, `tx` is 1.
- R4: The byte is captured at the accepting edge. Changes on `data_in` after that edge do not change the frame being sent.
- R5: `busy` is 1 from the cycle after the accepting edge for exactly 10×`CLKS_PER_BIT` cycles. Then it returns to 0.
- R6: A high `start` while `busy` is 1 is ignored. It neither restarts nor lengthens the frame.
- R7: After the last stop-bit cycle, the block is idle for at least one cycle. A `start` high at the first edge after that cycle begins a new frame at once.
- R8: A synchronous active-high `rst` forces `ST_IDLE`, sets `tx` to 1 and `busy` to 0, and clears the slot and cycle counters. This holds even in the middle of a frame.
- R9: The slot index never exceeds 9. The cycle counter never reaches `CLKS_PER_BIT`. Both start from 0 in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Send request, taken only while idle |
| data_in | input | 8 | Byte to send, captured when a request is taken |
| tx | output | 1 | Serial line output, high when idle |
| busy | output | 1 | High while a frame is being sent |

## Verification
The assertions check, on every cycle:
- that the line is high whenever the block is not busy;
- that a frame opens with a low start bit;
- that `tx` stays steady within a slot;
- that the slot index steps by one at each slot boundary;
- that the counters stay within range;
- that the block goes idle right after the last stop cycle.

The assertions cannot tell whether the data bits match the byte captured at acceptance. That comes out only in the bench scenarios, which compare every cycle of each frame against a computed reference. The scenarios include noisy `start` and `data_in` during a frame, back-to-back requests, and a reset in mid-frame followed by a fresh frame.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ctl_state_e;

    localparam int unsigned SLOT_W      = 4;
    localparam int unsigned FRAME_SLOTS = 10;
    localparam int unsigned DATA_W      = 8;
    localparam logic [SLOT_W-1:0] SLOT_STOP = SLOT_W'(FRAME_SLOTS - 1);
endpackage

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
    parameter int unsigned CPB   = 16,
    localparam int unsigned CYC_W = $clog2(CPB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CYC_W-1:0] cyc_q,
    output logic             slot_end
);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CPB - 1);

    assign slot_end = run && (cyc_q == CYC_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || slot_end) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/sftx_slot_counter.sv
module sftx_slot_counter
    import sftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    output logic [SLOT_W-1:0] slot_q,
    output logic              at_stop
);
    assign at_stop = (slot_q == SLOT_STOP);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot_q <= '0;
        end else if (advance) begin
            slot_q <= at_stop ? '0 : slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/sftx_frame_mux.sv
module sftx_frame_mux
    import sftx_pkg::*;
(
    input  logic              sending,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] byte_q,
    output logic              line
);
    logic [2:0] bit_idx;

    assign bit_idx = 3'(slot - 1'b1);

    always_comb begin
        if (!sending) begin
            line = 1'b1;
        end else begin
            unique case (slot)
                4'd0:      line = 1'b0;
                SLOT_STOP: line = 1'b1;
                4'd1, 4'd2, 4'd3, 4'd4,
                4'd5, 4'd6, 4'd7, 4'd8:
                           line = byte_q[bit_idx];
                default:   line = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] data_in,
    output logic       tx,
    output logic       busy
);
    localparam int unsigned CYC_W = $clog2(CLKS_PER_BIT);

    ctl_state_e        state_q, state_d;
    logic [DATA_W-1:0] byte_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              slot_end;
    logic              at_stop;
    logic              accept;
    logic              sending;
    logic              line;

    assign sending = (state_q == ST_SEND);
    assign accept  = (state_q == ST_IDLE) && start;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (slot_end && at_stop) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and byte capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) byte_q <= data_in;
        end
    end

    sftx_bit_timer #(.CPB(CLKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (sending),
        .cyc_q    (cyc_q),
        .slot_end (slot_end)
    );

    sftx_slot_counter u_slots (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .advance (slot_end),
        .slot_q  (slot_q),
        .at_stop (at_stop)
    );

    sftx_frame_mux u_mux (
        .sending (sending),
        .slot    (slot_q),
        .byte_q  (byte_q),
        .line    (line)
    );

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin tx = 1'b1; busy = 1'b0; end
            ST_SEND: begin tx = line; busy = 1'b1; end
            default: begin tx = 1'b1; busy = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sftx_checker.sv
module sftx_checker #(
    parameter int unsigned CPB   = 16,
    localparam int unsigned CYC_W = $clog2(CPB)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             tx,
    input logic             busy,
    input logic [3:0]       slot,
    input logic [CYC_W-1:0] cyc
);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CPB - 1);

    p_idle_line_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    p_start_bit_low_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    p_accept_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && cyc != '0) |-> $stable(tx));

    p_slot_step_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cyc == CYC_LAST && slot != 4'd9) |=> (slot == $past(slot) + 4'd1));

    p_slot_range_r9: assert property (@(posedge clk) disable iff (rst)
        (slot <= 4'd9) && (cyc <= CYC_LAST));

    p_finish_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && slot == 4'd9 && cyc == CYC_LAST) |=> !busy);

    p_reset_state_r8: assert property (@(posedge clk)
        rst |=> (!busy && tx && slot == 4'd0 && cyc == '0));
endmodule

bind serial_frame_tx sftx_checker #(.CPB(CLKS_PER_BIT)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .tx    (tx),
    .busy  (busy),
    .slot  (slot_q),
    .cyc   (cyc_q)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
    localparam int unsigned CPB = 5;
    localparam int unsigned FRAME_CYC = 10 * CPB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       tx;
    logic       busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serial_frame_tx #(.CLKS_PER_BIT(CPB)) dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .data_in (data_in),
        .tx      (tx),
        .busy    (busy)
    );

    function automatic logic exp_line(input logic [7:0] b, input int slot);
        if (slot == 0) return 1'b0;
        if (slot == 9) return 1'b1;
        return b[slot-1];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge while idle. Sends one frame and checks every cycle.
    task automatic run_frame(input logic [7:0] b, input bit noisy, input bit hold_last);
        start   = 1'b1;
        data_in = b;
        @(negedge clk);
        for (int k = 0; k < FRAME_CYC; k++) begin
            check("R2/R1 tx", tx, exp_line(b, k / CPB));
            check("R5 busy", busy, 1'b1);
            if (noisy) begin
                start   = 1'($urandom);       // R6 ignored while busy
                data_in = 8'($urandom);       // R4 must not alter frame
            end else begin
                start = 1'b0;
            end
            if (hold_last && k == FRAME_CYC - 1) start = 1'b1;
            @(negedge clk);
        end
        check("R7 idle busy", busy, 1'b0);
        check("R7 idle tx", tx, 1'b1);
        start = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R8 reset busy", busy, 1'b0);
        check("R8 reset tx", tx, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R3 idle tx", tx, 1'b1);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 idle tx quiet", tx, 1'b1);
        check("R3 idle busy", busy, 1'b0);

        // directed corner bytes
        run_frame(8'h00, 1'b0, 1'b0);
        run_frame(8'hFF, 1'b0, 1'b0);
        run_frame(8'hA5, 1'b1, 1'b0);
        run_frame(8'h01, 1'b0, 1'b0);
        run_frame(8'h80, 1'b0, 1'b0);

        // R7: start held over the last edge is ignored, accepted one cycle later
        run_frame(8'h3C, 1'b0, 1'b1);
        run_frame(8'hC3, 1'b1, 1'b0);

        // R8: reset in mid-frame
        start = 1'b1;
        data_in = 8'h5A;
        @(negedge clk);
        start = 1'b0;
        repeat (23) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 midframe busy", busy, 1'b0);
        check("R8 midframe tx", tx, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        // R9: counters restart from zero, so a fresh frame has exact timing
        run_frame(8'h96, 1'b0, 1'b0);

        // random frames, with random noise and random idle gaps
        for (int n = 0; n < 30; n++) begin
            run_frame(8'($urandom), 1'($urandom), 1'b0);
            for (int g = 0; g < int'($urandom % 3); g++) begin
                @(negedge clk);
                check("R3 gap tx", tx, 1'b1);
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule